// File: doc/BRIEF.md
# SPI Register Access Slave

This block is the serial front end of a bank of 16-bit registers addressed by 10 bits. An external SPI master lowers chip select, sends a 16-bit command word and then either writes or reads as many 16-bit words as it likes. Each word moves the register address on by one, and raising chip select ends the burst. A command is only obeyed when its top five bits carry a fixed pattern. Any other frame is dropped silently.

The SPI pins are sampled on the local clock `clk` through synchronisers, so SCLK must be slow compared with `clk`. SCLK must stay high for at least four `clk` cycles and low for at least four. Mode 0 is used: DIN is captured on rising SCLK and DOUT moves on falling SCLK. The register bank sits behind a plain port. A read strobe returns data on the following `clk` cycle, and a write strobe is taken in the cycle it is asserted. The bank is always ready, so this port has no back-pressure. The serial side also cannot be stalled: the master's timing, bounded by the SCLK limits above, is the only flow control.

Top module: `spi_regbank_slave`

## Requirements
- R1: The command is the first 16 DIN bits of a frame, most significant bit first. Bits [15:11] must be 5'b11100, bit [10] = 1 selects read and 0 selects write, and bits [9:0] give the starting address.
- R2: A frame whose bits [15:11] differ from 5'b11100 produces no read or write strobe, and `spi_dout_oe` stays 0 until chip select rises.
- R3: In a read, each register word appears on `spi_dout` as 16 bits, bit 15 first. The first bit is driven after the falling SCLK edge that follows the 16th command bit, and each later bit follows the next falling edge.
- R4: After every complete 16-bit word, read or written, the address grows by one, for as long as `spi_cs_n` stays low.
- R5: The address wraps from 10'h3FF to 10'h000, for reads and for writes.
- R6: In a write, each group of 16 DIN bits after the command, MSB first, is written once to the current address with a single-cycle `reg_wr_en` pulse.
- R7: `spi_dout_oe` is 0 while idle and during the command word. It returns to 0 within 6 clk cycles of `spi_cs_n` rising. DIN values during a read have no effect.
- R8: Raising `spi_cs_n` at any point discards a partial word and returns the decoder to idle, so that the next frame is decoded from its first bit.
- R9: `reg_rd_en` is a single-cycle pulse, never together with `reg_wr_en`. The data is taken from `reg_rd_data` on the next cycle. One read is issued at the start of a read frame and one after each completed word.
- R10: After reset, `spi_dout_oe`, `reg_rd_en` and `reg_wr_en` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_sclk | input | 1 | Serial clock from the master |
| spi_cs_n | input | 1 | Active-low chip select |
| spi_din | input | 1 | Serial data in |
| spi_dout | output | 1 | Serial data out, high impedance when not enabled |
| spi_dout_oe | output | 1 | Output enable for `spi_dout` |
| reg_addr | output | 10 | Register bank address |
| reg_rd_en | output | 1 | Read strobe |
| reg_rd_data | input | 16 | Read data, valid the cycle after `reg_rd_en` |
| reg_wr_en | output | 1 | Write strobe |
| reg_wr_data | output | 16 | Write data |

## Verification
Read bursts start at a low address and in the middle of the map, with random DIN bits during the data phase. Matching every word against a model of the bank separates correct MSB-first ordering and address stepping from off-by-one fetch timing. A write burst that straddles 10'h3FF, followed by a readback across the same boundary, shows the wrap in both directions. A frame with a wrong enable pattern, a write cut off after eight bits and a read cut off mid-word each test the discard paths, and the model's own write queue confirms that the bank saw no stray strobe.

// File: rtl/srs_pkg.sv
package srs_pkg;
  typedef enum logic [1:0] {
    FR_CMD   = 2'd0,
    FR_READ  = 2'd1,
    FR_WRITE = 2'd2,
    FR_DROP  = 2'd3
  } frame_state_e;
endpackage

// File: rtl/srs_sync.sv
module srs_sync #(
  parameter int            W       = 3,
  parameter int            STAGES  = 2,
  parameter logic [W-1:0]  RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_in,
  output logic [W-1:0] d_out
);
  logic [W-1:0] chain [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[s] <= RST_VAL;
          else        chain[s] <= d_in;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[s] <= RST_VAL;
          else        chain[s] <= chain[s-1];
        end
      end
    end
  endgenerate

  assign d_out = chain[STAGES-1];
endmodule

// File: rtl/srs_frame.sv
module srs_frame
  import srs_pkg::*;
#(
  parameter int              ADDR_W = 10,
  parameter int              DATA_W = 16,
  parameter int              EN_W   = 5,
  parameter logic [EN_W-1:0] EN_PAT = 5'b11100
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel,
  input  logic              sclk_rise,
  input  logic              din,
  input  logic              tx_word_done,
  output frame_state_e      state,
  output logic [ADDR_W-1:0] addr,
  output logic              rd_en,
  output logic              wr_en,
  output logic [DATA_W-1:0] wr_data
);
  localparam int CMD_W     = EN_W + 1 + ADDR_W;
  localparam int SH_W      = (CMD_W > DATA_W) ? CMD_W : DATA_W;
  localparam int CNT_W     = $clog2(SH_W + 1);
  localparam logic [CNT_W-1:0] CMD_LAST  = CNT_W'(CMD_W - 1);
  localparam logic [CNT_W-1:0] DATA_LAST = CNT_W'(DATA_W - 1);

  frame_state_e      state_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [SH_W-1:0]   sh_q;
  logic [SH_W-1:0]   sh_nxt;
  logic [CMD_W-1:0]  cmd_nxt;
  logic [ADDR_W-1:0] addr_q;
  logic              rd_en_q;
  logic              wr_en_q;
  logic [DATA_W-1:0] wr_data_q;
  logic              cmd_ok;
  logic              cmd_is_rd;

  assign sh_nxt    = {sh_q[SH_W-2:0], din};
  assign cmd_nxt   = sh_nxt[CMD_W-1:0];
  assign cmd_ok    = (cmd_nxt[CMD_W-1 -: EN_W] == EN_PAT);
  assign cmd_is_rd = cmd_nxt[ADDR_W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= FR_CMD;
      cnt_q     <= '0;
      sh_q      <= '0;
      addr_q    <= '0;
      rd_en_q   <= 1'b0;
      wr_en_q   <= 1'b0;
      wr_data_q <= '0;
    end else begin
      rd_en_q <= 1'b0;
      wr_en_q <= 1'b0;
      if (wr_en_q) addr_q <= addr_q + 1'b1;
      if (!sel) begin
        state_q <= FR_CMD;
        cnt_q   <= '0;
        sh_q    <= '0;
      end else begin
        case (state_q)
          FR_CMD: begin
            if (sclk_rise) begin
              sh_q <= sh_nxt;
              if (cnt_q == CMD_LAST) begin
                cnt_q <= '0;
                if (cmd_ok) begin
                  addr_q <= cmd_nxt[ADDR_W-1:0];
                  if (cmd_is_rd) begin
                    state_q <= FR_READ;
                    rd_en_q <= 1'b1;
                  end else begin
                    state_q <= FR_WRITE;
                  end
                end else begin
                  state_q <= FR_DROP;
                end
              end else begin
                cnt_q <= cnt_q + 1'b1;
              end
            end
          end
          FR_READ: begin
            if (tx_word_done) begin
              addr_q  <= addr_q + 1'b1;
              rd_en_q <= 1'b1;
            end
          end
          FR_WRITE: begin
            if (sclk_rise) begin
              sh_q <= sh_nxt;
              if (cnt_q == DATA_LAST) begin
                cnt_q     <= '0;
                wr_en_q   <= 1'b1;
                wr_data_q <= sh_nxt[DATA_W-1:0];
              end else begin
                cnt_q <= cnt_q + 1'b1;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign state   = state_q;
  assign addr    = addr_q;
  assign rd_en   = rd_en_q;
  assign wr_en   = wr_en_q;
  assign wr_data = wr_data_q;

  AST_DROP_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == FR_DROP) |-> (!rd_en_q && !wr_en_q)); // R2
  AST_WR_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en_q |=> !wr_en_q); // R6
  AST_WR_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en_q |=> (addr_q == ADDR_W'($past(addr_q) + 1'b1))); // R4
  AST_DESEL_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !sel |=> (state_q == FR_CMD && cnt_q == '0)); // R8
  AST_RD_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en_q |=> !rd_en_q); // R9
  AST_ACCESS_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_en_q && wr_en_q)); // R9
endmodule

// File: rtl/srs_tx.sv
module srs_tx #(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_active,
  input  logic              sclk_fall,
  input  logic              fetch,
  input  logic [DATA_W-1:0] rd_data,
  output logic              dout,
  output logic              oe,
  output logic              word_done
);
  localparam int CNT_W = $clog2(DATA_W);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(DATA_W - 1);

  logic [DATA_W-1:0] tx_q;
  logic [CNT_W-1:0]  fcnt_q;
  logic              ld_pend_q;
  logic              dout_q;
  logic              oe_q;
  logic              done_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_q      <= '0;
      fcnt_q    <= '0;
      ld_pend_q <= 1'b0;
      dout_q    <= 1'b0;
      oe_q      <= 1'b0;
      done_q    <= 1'b0;
    end else begin
      done_q    <= 1'b0;
      ld_pend_q <= fetch;
      if (!rd_active) begin
        oe_q      <= 1'b0;
        fcnt_q    <= '0;
        ld_pend_q <= 1'b0;
      end else if (sclk_fall) begin
        dout_q <= tx_q[DATA_W-1];
        tx_q   <= {tx_q[DATA_W-2:0], 1'b0};
        oe_q   <= 1'b1;
        if (fcnt_q == LAST) begin
          fcnt_q <= '0;
          done_q <= 1'b1;
        end else begin
          fcnt_q <= fcnt_q + 1'b1;
        end
      end else if (ld_pend_q) begin
        tx_q <= rd_data;
      end
    end
  end

  assign dout      = dout_q;
  assign oe        = oe_q;
  assign word_done = done_q;

  AST_OE_DROPS_OUTSIDE_READ: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_active |=> !oe_q); // R7
  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q); // R4
endmodule

// File: rtl/spi_regbank_slave.sv
module spi_regbank_slave
  import srs_pkg::*;
#(
  parameter int              ADDR_W      = 10,
  parameter int              DATA_W      = 16,
  parameter int              EN_W        = 5,
  parameter logic [EN_W-1:0] EN_PAT      = 5'b11100,
  parameter int              SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              spi_sclk,
  input  logic              spi_cs_n,
  input  logic              spi_din,
  output logic              spi_dout,
  output logic              spi_dout_oe,
  output logic [ADDR_W-1:0] reg_addr,
  output logic              reg_rd_en,
  input  logic [DATA_W-1:0] reg_rd_data,
  output logic              reg_wr_en,
  output logic [DATA_W-1:0] reg_wr_data
);
  logic [2:0]   pins_s;
  logic         cs_n_s;
  logic         sclk_s;
  logic         din_s;
  logic         sclk_d;
  logic         sclk_rise;
  logic         sclk_fall;
  frame_state_e state;
  logic         word_done;
  logic         dout_q;
  logic         oe_q;

  srs_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_in  ({spi_cs_n, spi_sclk, spi_din}),
    .d_out (pins_s)
  );

  assign cs_n_s = pins_s[2];
  assign sclk_s = pins_s[1];
  assign din_s  = pins_s[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sclk_d <= 1'b0;
    else        sclk_d <= sclk_s;
  end

  assign sclk_rise = sclk_s & ~sclk_d & ~cs_n_s;
  assign sclk_fall = ~sclk_s & sclk_d & ~cs_n_s;

  srs_frame #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .EN_W   (EN_W),
    .EN_PAT (EN_PAT)
  ) u_frame (
    .clk          (clk),
    .rst_n        (rst_n),
    .sel          (~cs_n_s),
    .sclk_rise    (sclk_rise),
    .din          (din_s),
    .tx_word_done (word_done),
    .state        (state),
    .addr         (reg_addr),
    .rd_en        (reg_rd_en),
    .wr_en        (reg_wr_en),
    .wr_data      (reg_wr_data)
  );

  srs_tx #(.DATA_W(DATA_W)) u_tx (
    .clk       (clk),
    .rst_n     (rst_n),
    .rd_active (state == FR_READ),
    .sclk_fall (sclk_fall),
    .fetch     (reg_rd_en),
    .rd_data   (reg_rd_data),
    .dout      (dout_q),
    .oe        (oe_q),
    .word_done (word_done)
  );

  assign spi_dout_oe = oe_q;
  assign spi_dout    = oe_q ? dout_q : 1'bz;

  AST_OE_NEEDS_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (spi_dout_oe && $past(spi_dout_oe)) |-> (state == FR_READ || $past(state) == FR_READ)); // R7
  AST_WORD_ONLY_IN_READ: assert property (@(posedge clk) disable iff (!rst_n)
    word_done |-> (state == FR_READ || $past(state) == FR_READ)); // R3
endmodule

// File: tb/tb_spi_regbank_slave.sv
module tb_spi_regbank_slave;
  localparam int HALF = 6;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        spi_sclk, spi_cs_n, spi_din;
  logic        spi_dout, spi_dout_oe;
  logic [9:0]  reg_addr;
  logic        reg_rd_en, reg_wr_en;
  logic [15:0] reg_rd_data, reg_wr_data;

  always #4 clk = ~clk;

  spi_regbank_slave dut (
    .clk(clk), .rst_n(rst_n), .spi_sclk(spi_sclk), .spi_cs_n(spi_cs_n),
    .spi_din(spi_din), .spi_dout(spi_dout), .spi_dout_oe(spi_dout_oe),
    .reg_addr(reg_addr), .reg_rd_en(reg_rd_en), .reg_rd_data(reg_rd_data),
    .reg_wr_en(reg_wr_en), .reg_wr_data(reg_wr_data)
  );

  function automatic logic [15:0] init_val(input int a);
    return 16'((a * 40503) ^ 16'hC3A5);
  endfunction

  // Register bank model: one-cycle read latency, writes checked against a queue.
  logic [15:0] mem [1024];
  logic [25:0] wq [$];
  int rd_cnt = 0;
  int w_chk = 0, w_err = 0;
  logic [25:0] w_exp;

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 1024; i++) mem[i] <= init_val(i);
      reg_rd_data <= '0;
    end else begin
      if (reg_rd_en) begin
        reg_rd_data <= mem[reg_addr];
        rd_cnt++;
      end
      if (reg_wr_en) begin
        mem[reg_addr] <= reg_wr_data;
        w_chk++;
        if (wq.size() == 0) begin
          w_err++;
          $display("FAIL R6 unexpected write actual=%h/%h expected=none", reg_addr, reg_wr_data);
        end else begin
          w_exp = wq.pop_front();
          if ({reg_addr, reg_wr_data} !== w_exp) begin
            w_err++;
            $display("FAIL R6 write actual=%h/%h expected=%h/%h",
                     reg_addr, reg_wr_data, w_exp[25:16], w_exp[15:0]);
          end
        end
      end
    end
  end

  // Per-clock comparison: reset strobes and enable quiet after deselect.
  int c_chk = 0, c_err = 0;
  int cs_hi_run = 0;
  always @(negedge clk) begin
    if (rst_n) begin
      cs_hi_run = spi_cs_n ? cs_hi_run + 1 : 0;
      if (cs_hi_run >= 7) begin
        c_chk++;
        if (spi_dout_oe !== 1'b0) begin
          c_err++;
          $display("FAIL R7 oe while deselected actual=%b expected=0", spi_dout_oe);
        end
      end
    end
  end

  int n_chk = 0, n_err = 0;
  int wd_err = 0;
  bit done = 0;
  logic [15:0] model [1024];

  task automatic chk(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  task automatic summary();
    $display("  CHECKS %0d ERRORS %0d", n_chk + w_chk + c_chk + wd_err,
             n_err + w_err + c_err + wd_err);
  endtask

  function automatic logic [15:0] cmdw(input logic [4:0] en, input bit rw, input logic [9:0] a);
    return {en, rw, a};
  endfunction

  task automatic begin_frame();
    spi_cs_n = 1'b0;
    repeat (HALF) @(negedge clk);
  endtask

  task automatic end_frame();
    spi_sclk = 1'b0;
    repeat (HALF) @(negedge clk);
    spi_cs_n = 1'b1;
    repeat (10) @(negedge clk);
  endtask

  task automatic shift_bits(input logic [15:0] w, input int n,
                            output logic [15:0] got, output int oe_hi);
    got = '0;
    oe_hi = 0;
    for (int i = 15; i > 15 - n; i--) begin
      spi_din = w[i];
      repeat (HALF) @(negedge clk);
      got[i] = spi_dout;
      if (spi_dout_oe === 1'b1) oe_hi++;
      spi_sclk = 1'b1;
      repeat (HALF) @(negedge clk);
      spi_sclk = 1'b0;
    end
  endtask

  task automatic do_read(input logic [9:0] a, input int n);
    logic [15:0] got;
    int oe_hi;
    logic [9:0] ad;
    begin_frame();
    shift_bits(cmdw(5'b11100, 1'b1, a), 16, got, oe_hi);
    chk(oe_hi == 0, "R7 oe during command", oe_hi, 0);
    for (int k = 0; k < n; k++) begin
      ad = a + 10'(k);
      shift_bits(16'($urandom), 16, got, oe_hi);
      chk(got === model[ad], "R3/R4/R5 read word", got, model[ad]);
      chk(oe_hi == 16, "R3 oe during data", oe_hi, 16);
    end
    end_frame();
    chk(spi_dout_oe === 1'b0, "R7 oe after frame", spi_dout_oe, 0);
  endtask

  task automatic do_write(input logic [9:0] a, input int n, input logic [15:0] seed);
    logic [15:0] got;
    int oe_hi;
    logic [9:0] ad;
    logic [15:0] d;
    begin_frame();
    shift_bits(cmdw(5'b11100, 1'b0, a), 16, got, oe_hi);
    for (int k = 0; k < n; k++) begin
      ad = a + 10'(k);
      d = seed + 16'(k * 16'h1111);
      wq.push_back({ad, d});
      model[ad] = d;
      shift_bits(d, 16, got, oe_hi);
      chk(oe_hi == 0, "R7 oe during write", oe_hi, 0);
    end
    end_frame();
    chk(wq.size() == 0, "R6 all words written", wq.size(), 0);
  endtask

  initial begin
    logic [15:0] got;
    int oe_hi;
    int rc;
    for (int i = 0; i < 1024; i++) model[i] = init_val(i);
    spi_sclk = 1'b0; spi_cs_n = 1'b1; spi_din = 1'b0; rst_n = 1'b0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(spi_dout_oe === 1'b0, "R10 reset oe", spi_dout_oe, 0);
    chk(reg_rd_en === 1'b0, "R10 reset rd_en", reg_rd_en, 0);
    chk(reg_wr_en === 1'b0, "R10 reset wr_en", reg_wr_en, 0);

    // R1 R3 R4 R9: burst of three reads, random DIN during data
    rc = rd_cnt;
    do_read(10'h005, 3);
    chk(rd_cnt - rc == 4, "R9 fetch count", rd_cnt - rc, 4);
    do_read(10'h1C3, 2);

    // R5 R6: write across the top of the map, then read back across it
    do_write(10'h3FF, 2, 16'hA55A);
    do_read(10'h3FE, 3);

    // R1: single write in the middle, readback around it
    do_write(10'h0AA, 1, 16'h1234);
    do_read(10'h0A9, 3);

    // R2: wrong enable pattern, read requested
    rc = rd_cnt;
    begin_frame();
    shift_bits(cmdw(5'b11101, 1'b1, 10'h005), 16, got, oe_hi);
    shift_bits(16'hFFFF, 16, got, oe_hi);
    chk(oe_hi == 0, "R2 dropped frame oe", oe_hi, 0);
    shift_bits(16'h0F0F, 16, got, oe_hi);
    chk(oe_hi == 0, "R2 dropped frame oe", oe_hi, 0);
    end_frame();
    chk(rd_cnt == rc, "R2 no read strobe", rd_cnt - rc, 0);

    // R2: wrong enable pattern, write requested (any strobe fails in the bank model)
    begin_frame();
    shift_bits(cmdw(5'b01100, 1'b0, 10'h020), 16, got, oe_hi);
    shift_bits(16'hDEAD, 16, got, oe_hi);
    end_frame();
    do_read(10'h020, 1);

    // R8: write cut after eight data bits, then a clean read
    begin_frame();
    shift_bits(cmdw(5'b11100, 1'b0, 10'h020), 16, got, oe_hi);
    shift_bits(16'hBEEF, 8, got, oe_hi);
    end_frame();
    do_read(10'h020, 1);

    // R8: read cut mid-word, enable must fall and next frame decodes afresh
    begin_frame();
    shift_bits(cmdw(5'b11100, 1'b1, 10'h100), 16, got, oe_hi);
    shift_bits(16'h0000, 16, got, oe_hi);
    chk(got === model[10'h100], "R3 first word before abort", got, model[10'h100]);
    shift_bits(16'h0000, 8, got, oe_hi);
    spi_sclk = 1'b0;
    repeat (HALF) @(negedge clk);
    spi_cs_n = 1'b1;
    repeat (6) @(negedge clk);
    chk(spi_dout_oe === 1'b0, "R8 oe after abort", spi_dout_oe, 0);
    repeat (6) @(negedge clk);
    do_read(10'h101, 2);

    chk(wq.size() == 0, "R6 no pending writes", wq.size(), 0);
    if (!done) begin
      done = 1;
      summary();
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      wd_err = 1;
      $display("FAIL watchdog actual=timeout expected=finish");
      summary();
      $finish;
    end
  end
endmodule